// File: doc/BRIEF.md
# Persistent Data Path Selection Controller

This block decodes the 16-bit control instructions of a small associative-memory device. It keeps two persistent routing choices. The first is the register that data-read cycles come from. The second is the register that data-write cycles go to, together with a mask select and a validity code for memory writes. These choices stay in force until another routing instruction replaces them. A one-shot override instruction sends only the next command read or command write to a chosen register. After that one cycle, command traffic returns to normal: reads go to status and writes go to the instruction decoder.

The block also owns a 12-bit address register that points into the memory array. A routing instruction with the address-field flag set makes the following command write an address word, which is loaded into that register. Every data cycle that reaches memory uses the current address and then moves it by one, up or down. The direction comes from bit 0 of a 16-bit control register. The 64-bit comparand and mask registers are written as four 16-bit segments. Writing the last segment produces a one-cycle compare pulse. The comparand, masks, memory array and match logic all sit outside the block.

All pins are plain control and status pins. The cycle strobe has no ready: the block accepts every strobed cycle in the clock edge where the strobe is high, and it never applies back-pressure.

Top module: `pdsel_ctrl`

## Requirements
- R1: After reset the source code and destination code are both 0 (comparand), the mask select and validity code are 0, the address register is 0, and there is no armed override and no pulse.
- R2: A command write of the form 0000 f000 0000 0sss sets the source code to sss from the next cycle. Words whose top four bits are not zero, and opcodes (bits 10:8) other than 0, 1 and 2, change no routing state.
- R3: A command write of the form 0000 f001 mmdd dvvv sets the mask select to mm, the destination to ddd and the validity code to vvv. It also restarts the segment count.
- R4: When bit 11 (f) of a routing instruction is 1, the next command write is an address word. Its bits 11:0 are loaded into the address register, address-load pulses for one cycle, and the word is not decoded as an instruction.
- R5: A data read whose source is 4 or 5, or a data write whose destination is 4 or 5, uses the address register and then moves it by one: up when control bit 0 is 0, down when it is 1. The count wraps modulo 4096 and address-step pulses for one cycle. Selecting code 5 leaves the address unchanged.
- R6: The instruction 0000 0010 00dd d000 arms an override of register ddd. The next command cycle, read or write, consumes it and clears it. An override write is never decoded as an instruction.
- R7: An override write to code 6 loads the control register, and one to code 7 loads the address register with an address-load pulse. Override writes to codes 3, 4 and 5 (next-free, source selector, destination selector) are ignored.
- R8: While an override is armed, read data shows one of the following, and it shows 0 at all other times:
  - code 4: the 12-bit device ID in bits 15:4 with the source code in bits 2:0;
  - code 5: mask select in bits 7:6, destination in bits 5:3 and validity in bits 2:0;
  - code 6: the control register;
  - code 7: the address register;
  - any other code: 0.
- R9: Compare pulses for one cycle after every fourth data write to destination 0, 1 or 2 since the last restart of the segment count. Data writes to memory never pulse it.
- R10: Data cycles whose source or destination is 0, 1 or 2 leave the address register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | Bus cycle strobe, one cycle per transfer |
| cyc_is_cmd | input | 1 | 1 for a command cycle, 0 for a data cycle |
| cyc_write | input | 1 | 1 for a write, 0 for a read |
| bus_in | input | 16 | Write data / instruction word |
| rd_data | output | 16 | Override read data |
| src_sel | output | 3 | Persistent data-read source code |
| dst_sel | output | 3 | Persistent data-write destination code |
| mask_sel | output | 2 | Mask select for data writes |
| valid_code | output | 3 | Validity setting for memory writes |
| ovr_armed | output | 1 | One-shot override pending |
| ovr_reg | output | 3 | Register chosen by the pending override |
| ar_value | output | 12 | Address register |
| ar_load | output | 1 | Address register was loaded last edge |
| ar_step | output | 1 | Address register stepped last edge |
| cmp_pulse | output | 1 | Automatic compare request |

## Verification
The hardest states to reach are the ones where two one-shot mechanisms are in play at once. One case is an armed override whose command write looks like a valid routing instruction, so that the write must go to a register and not to the decoder. The other is a segment count cut short by a new destination. The stimulus first arms an override with a control-register target and then writes a word that would also decode as a source select. It checks that the source is unchanged while the step direction flips. It also stops a comparand write sequence after two segments, issues a new destination, and confirms that the compare pulse waits for four further writes. The address wrap is reached by loading 0xFFE through an address word and stepping across the top.

// File: rtl/pdsel_pkg.sv
package pdsel_pkg;
  localparam int BUS_W = 16;

  localparam logic [2:0] CODE_CMP  = 3'd0;
  localparam logic [2:0] CODE_MSK1 = 3'd1;
  localparam logic [2:0] CODE_MSK2 = 3'd2;
  localparam logic [2:0] CODE_NF   = 3'd3;
  localparam logic [2:0] CODE_MEMA = 3'd4;  // memory at address field / PS in override
  localparam logic [2:0] CODE_MEMR = 3'd5;  // memory at [AR] / PD in override
  localparam logic [2:0] CODE_CTL  = 3'd6;
  localparam logic [2:0] CODE_AR   = 3'd7;

  localparam logic [2:0] OP_SRC = 3'd0;
  localparam logic [2:0] OP_DST = 3'd1;
  localparam logic [2:0] OP_OVR = 3'd2;

  typedef struct packed {
    logic       is_src;
    logic       is_dst;
    logic       is_ovr;
    logic       fflag;
    logic [1:0] mm;
    logic [2:0] ddd;
    logic [2:0] low3;
  } instr_t;

  function automatic logic is_mem(input logic [2:0] c);
    return (c == CODE_MEMA) || (c == CODE_MEMR);
  endfunction

  function automatic logic is_seg_reg(input logic [2:0] c);
    return (c == CODE_CMP) || (c == CODE_MSK1) || (c == CODE_MSK2);
  endfunction
endpackage

// File: rtl/pdsel_decode.sv
module pdsel_decode
  import pdsel_pkg::*;
(
  input  logic [BUS_W-1:0] word,
  output instr_t           ins
);
  logic       top_zero;
  logic [2:0] op;

  always_comb begin
    top_zero   = (word[15:12] == 4'h0);
    op         = word[10:8];
    ins.fflag  = word[11];
    ins.mm     = word[7:6];
    ins.ddd    = word[5:3];
    ins.low3   = word[2:0];
    ins.is_src = top_zero && (op == OP_SRC) && (word[7:3] == 5'd0);
    ins.is_dst = top_zero && (op == OP_DST);
    ins.is_ovr = top_zero && (op == OP_OVR) && !word[11]
                 && (word[7:6] == 2'd0) && (word[2:0] == 3'd0);
  end
endmodule

// File: rtl/pdsel_addr.sv
module pdsel_addr #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_en,
  input  logic              step_down,
  output logic [ADDR_W-1:0] ar_q,
  output logic              load_p,
  output logic              step_p
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ar_q   <= '0;
      load_p <= 1'b0;
      step_p <= 1'b0;
    end else begin
      load_p <= load_en;
      step_p <= step_en && !load_en;
      if (load_en)
        ar_q <= load_val;
      else if (step_en)
        ar_q <= step_down ? ar_q - ONE : ar_q + ONE;
    end
  end

  // R5: a step moves the address by exactly one in the chosen direction
  p_step_by_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_p |-> ((ar_q == $past(ar_q) + ONE) || (ar_q == $past(ar_q) - ONE)));
endmodule

// File: rtl/pdsel_seg.sv
module pdsel_seg #(
  parameter int SEGS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wr_en,
  output logic cmp_p
);
  localparam int SEG_W = (SEGS > 2) ? $clog2(SEGS) : 1;
  localparam logic [SEG_W-1:0] LAST = SEG_W'(SEGS - 1);

  logic [SEG_W-1:0] seg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q <= '0;
      cmp_p <= 1'b0;
    end else begin
      cmp_p <= 1'b0;
      if (clr)
        seg_q <= '0;
      else if (wr_en) begin
        if (seg_q == LAST) begin
          seg_q <= '0;
          cmp_p <= 1'b1;
        end else
          seg_q <= seg_q + SEG_W'(1);
      end
    end
  end

  // R9: the compare request never lasts two cycles
  p_cmp_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_p |=> !cmp_p);
endmodule

// File: rtl/pdsel_ctrl.sv
module pdsel_ctrl
  import pdsel_pkg::*;
#(
  parameter int          ADDR_W = 12,
  parameter int          SEGS   = 4,
  parameter logic [11:0] DEV_ID = 12'hA5C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid,
  input  logic              cyc_is_cmd,
  input  logic              cyc_write,
  input  logic [15:0]       bus_in,
  output logic [15:0]       rd_data,
  output logic [2:0]        src_sel,
  output logic [2:0]        dst_sel,
  output logic [1:0]        mask_sel,
  output logic [2:0]        valid_code,
  output logic              ovr_armed,
  output logic [2:0]        ovr_reg,
  output logic [ADDR_W-1:0] ar_value,
  output logic              ar_load,
  output logic              ar_step,
  output logic              cmp_pulse
);
  instr_t          dec;
  logic            addr_pend;
  logic [BUS_W-1:0] ctrl_q;
  logic            cmd_wr, cmd_rd, dat_wr, dat_rd;
  logic            take_addr, ovr_wr, instr_wr;
  logic            ld_en, st_en, seg_wr, seg_clr;

  pdsel_decode u_dec (.word(bus_in), .ins(dec));

  always_comb begin
    cmd_wr    = cyc_valid && cyc_is_cmd && cyc_write;
    cmd_rd    = cyc_valid && cyc_is_cmd && !cyc_write;
    dat_wr    = cyc_valid && !cyc_is_cmd && cyc_write;
    dat_rd    = cyc_valid && !cyc_is_cmd && !cyc_write;
    take_addr = cmd_wr && addr_pend;
    ovr_wr    = cmd_wr && !addr_pend && ovr_armed;
    instr_wr  = cmd_wr && !addr_pend && !ovr_armed;
    ld_en     = take_addr || (ovr_wr && ovr_reg == CODE_AR);
    st_en     = (dat_wr && is_mem(dst_sel)) || (dat_rd && is_mem(src_sel));
    seg_wr    = dat_wr && is_seg_reg(dst_sel);
    seg_clr   = instr_wr && dec.is_dst;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_sel    <= CODE_CMP;
      dst_sel    <= CODE_CMP;
      mask_sel   <= 2'd0;
      valid_code <= 3'd0;
      ovr_armed  <= 1'b0;
      ovr_reg    <= 3'd0;
      addr_pend  <= 1'b0;
      ctrl_q     <= '0;
    end else begin
      if (take_addr)
        addr_pend <= 1'b0;
      if (ovr_wr || (cmd_rd && ovr_armed))
        ovr_armed <= 1'b0;
      if (ovr_wr && ovr_reg == CODE_CTL)
        ctrl_q <= bus_in;
      if (instr_wr) begin
        if (dec.is_src) begin
          src_sel   <= dec.low3;
          addr_pend <= dec.fflag;
        end
        if (dec.is_dst) begin
          mask_sel   <= dec.mm;
          dst_sel    <= dec.ddd;
          valid_code <= dec.low3;
          addr_pend  <= dec.fflag;
        end
        if (dec.is_ovr) begin
          ovr_armed <= 1'b1;
          ovr_reg   <= dec.ddd;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (ovr_armed) begin
      case (ovr_reg)
        CODE_MEMA: rd_data = {DEV_ID, 1'b0, src_sel};
        CODE_MEMR: rd_data = {8'd0, mask_sel, dst_sel, valid_code};
        CODE_CTL:  rd_data = ctrl_q;
        CODE_AR:   rd_data = {{(BUS_W-ADDR_W){1'b0}}, ar_value};
        default:   rd_data = '0;
      endcase
    end
  end

  pdsel_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load_en(ld_en), .load_val(bus_in[ADDR_W-1:0]),
    .step_en(st_en), .step_down(ctrl_q[0]), .ar_q(ar_value),
    .load_p(ar_load), .step_p(ar_step));

  pdsel_seg #(.SEGS(SEGS)) u_seg (
    .clk(clk), .rst_n(rst_n), .clr(seg_clr), .wr_en(seg_wr), .cmp_p(cmp_pulse));

  // R2: routing changes only through command cycles
  p_route_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cyc_valid && cyc_is_cmd) |=> $stable(src_sel) && $stable(dst_sel));
  // R4: an address word lands in the address register
  p_addr_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_is_cmd && cyc_write && addr_pend)
      |=> ar_load && (ar_value == $past(bus_in[ADDR_W-1:0])));
  // R6: any command cycle consumes an armed override
  p_ovr_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_is_cmd && ovr_armed && !addr_pend) |=> !ovr_armed);
  // R7: an override write leaves the selectors alone
  p_sel_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_is_cmd && cyc_write && ovr_armed && !addr_pend)
      |=> $stable(src_sel) && $stable(dst_sel) && $stable(mask_sel));
endmodule

// File: tb/pdsel_ctrl_bench.sv
module pdsel_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_valid = 1'b0, cyc_is_cmd = 1'b0, cyc_write = 1'b0;
  logic [15:0] bus_in = '0;
  logic [15:0] rd_data;
  logic [2:0]  src_sel, dst_sel, valid_code, ovr_reg;
  logic [1:0]  mask_sel;
  logic        ovr_armed, ar_load, ar_step, cmp_pulse;
  logic [11:0] ar_value;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pdsel_ctrl u_pdsel_ctrl (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_is_cmd(cyc_is_cmd),
    .cyc_write(cyc_write), .bus_in(bus_in), .rd_data(rd_data),
    .src_sel(src_sel), .dst_sel(dst_sel), .mask_sel(mask_sel),
    .valid_code(valid_code), .ovr_armed(ovr_armed), .ovr_reg(ovr_reg),
    .ar_value(ar_value), .ar_load(ar_load), .ar_step(ar_step),
    .cmp_pulse(cmp_pulse));

  // {instruction word, expected src, mask, dst, validity}
  localparam logic [26:0] VEC [8] = '{
    {16'h0001, 3'd1, 2'd0, 3'd0, 3'd0},
    {16'h0002, 3'd2, 2'd0, 3'd0, 3'd0},
    {16'h018B, 3'd2, 2'd2, 3'd1, 3'd3},
    {16'h016E, 3'd2, 2'd1, 3'd5, 3'd6},
    {16'h0500, 3'd2, 2'd1, 3'd5, 3'd6},
    {16'h0005, 3'd5, 2'd1, 3'd5, 3'd6},
    {16'h1001, 3'd5, 2'd1, 3'd5, 3'd6},
    {16'h0000, 3'd0, 2'd1, 3'd5, 3'd6}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic cmd, input logic wr, input logic [15:0] d);
    @(negedge clk);
    cyc_valid = 1'b1; cyc_is_cmd = cmd; cyc_write = wr; bus_in = d;
    @(negedge clk);
    cyc_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 src", src_sel, 0);
    check("R1 dst", dst_sel, 0);
    check("R1 mask/valid", {mask_sel, valid_code}, 0);
    check("R1 ar", ar_value, 0);
    check("R1 flags", {ovr_armed, ar_load, ar_step, cmp_pulse}, 0);
    check("R8 idle rd_data", rd_data, 0);

    for (int i = 0; i < 8; i++) begin
      cyc(1, 1, VEC[i][26:11]);
      check("R2 table src", src_sel, VEC[i][10:8]);
      check("R3 table mask/dst/valid", {mask_sel, dst_sel, valid_code}, VEC[i][7:0]);
    end

    // R4: flagged destination select followed by address word
    cyc(1, 1, 16'h0921);
    check("R3 dst mem", dst_sel, 4);
    cyc(1, 1, 16'h0FFE);
    check("R4 address", ar_value, 12'hFFE);
    check("R4 load pulse", ar_load, 1);
    check("R4 word not decoded", {mask_sel, dst_sel, valid_code}, 8'h21);
    // R5: up-stepping and wrap
    cyc(0, 1, 16'h1234);
    check("R5 step up", ar_value, 12'hFFF);
    check("R5 step pulse", ar_step, 1);
    cyc(0, 1, 16'h1234);
    check("R5 wrap", ar_value, 12'h000);
    // R6: override of control, write looks like a source select
    cyc(1, 1, 16'h0230);
    check("R6 armed", {ovr_armed, ovr_reg}, 4'hE);
    cyc(1, 1, 16'h0001);
    check("R6 not decoded", src_sel, 0);
    check("R6 cleared", ovr_armed, 0);
    cyc(0, 1, 16'h0000);
    check("R7 ctrl down step", ar_value, 12'hFFF);
    // R8 readbacks
    cyc(1, 1, 16'h0230);
    check("R8 ctrl read", rd_data, 16'h0001);
    cyc(1, 0, 16'h0000);
    check("R6 read consumes", ovr_armed, 0);
    check("R8 after read", rd_data, 0);
    cyc(1, 1, 16'h0220);
    check("R8 source/id read", rd_data, 16'hA5C0);
    cyc(1, 0, 16'h0000);
    cyc(1, 1, 16'h0228);
    check("R8 dest read", rd_data, 16'h0021);
    cyc(1, 0, 16'h0000);
    cyc(1, 1, 16'h0238);
    check("R8 ar read", rd_data, 16'h0FFF);
    cyc(1, 0, 16'h0000);
    // R7: protected and writable targets
    cyc(1, 1, 16'h0220);
    cyc(1, 1, 16'h0007);
    check("R7 source protected", src_sel, 0);
    cyc(1, 1, 16'h0228);
    cyc(1, 1, 16'h0000);
    check("R7 dest protected", {mask_sel, dst_sel, valid_code}, 8'h21);
    cyc(1, 1, 16'h0238);
    cyc(1, 1, 16'h0123);
    check("R7 ar write", ar_value, 12'h123);
    check("R7 ar load pulse", ar_load, 1);
    // R5: memory at [AR] keeps the address, then steps down
    cyc(1, 1, 16'h0005);
    check("R5 [AR] keeps", ar_value, 12'h123);
    cyc(0, 0, 16'h0000);
    check("R5 read steps down", ar_value, 12'h122);
    // R10: register routes do not step
    cyc(1, 1, 16'h0000);
    cyc(1, 1, 16'h0100);
    cyc(0, 0, 16'h0000);
    check("R10 read no step", {ar_step, ar_value}, {1'b0, 12'h122});
    // R9: four comparand segments
    for (int i = 0; i < 3; i++) begin
      cyc(0, 1, 16'hAAAA);
      check("R9 no early cmp", cmp_pulse, 0);
    end
    check("R10 write no step", ar_value, 12'h122);
    cyc(0, 1, 16'hAAAA);
    check("R9 cmp on fourth", cmp_pulse, 1);
    @(negedge clk);
    check("R9 cmp one cycle", cmp_pulse, 0);
    // R3/R9: new destination restarts the count
    cyc(0, 1, 16'h1111);
    cyc(0, 1, 16'h2222);
    cyc(1, 1, 16'h0108);
    for (int i = 0; i < 3; i++) begin
      cyc(0, 1, 16'h3333);
      check("R3 count restarted", cmp_pulse, 0);
    end
    cyc(0, 1, 16'h4444);
    check("R9 mask cmp", cmp_pulse, 1);
    // R9: memory writes never compare
    cyc(1, 1, 16'h0120);
    for (int i = 0; i < 4; i++) begin
      cyc(0, 1, 16'h5555);
      check("R9 memory no cmp", cmp_pulse, 0);
    end
    check("R5 four steps down", ar_value, 12'h11E);
    // R4: flagged source select
    cyc(1, 1, 16'h0804);
    cyc(1, 1, 16'h0ABC);
    check("R4 source address", {src_sel, ar_value}, {3'd4, 12'hABC});
    cyc(0, 0, 16'h0000);
    check("R5 first access then step", ar_value, 12'hABB);
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      done = 1'b1;
    end
  end

  initial begin
    wait (done);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule